// File: doc/BRIEF.md
# Event Timestamp Capture Register File

This block collects the hardware timestamps taken at the start of precision-time event frames, in both the send and the receive direction. Each capture carries a seconds and a nanoseconds value, the frame's sequence number, its 4-bit message type and a flag that marks it as a transmit capture. Captures go into a small first-in first-out store. A pending line tells software that at least one capture is waiting.

Software reads a capture through a 16-bit register window in three steps. First it writes the start bit of the control register, which copies the oldest stored capture into a set of snapshot registers. It then reads the six snapshot words at its own pace. Finally it writes the end bit, which releases the capture, and then writes zero to return the handshake to idle. Because the snapshot is frozen for the whole read, the words always belong to one capture, even when new captures arrive between the word reads.

Register map: address 0 is status, address 1 is control, addresses 2 to 7 are the snapshot words.

Top module: `evt_stamp_regs`

## Requirements
- R1: Status bit 1 (address 0) and `stamp_pending_o` are 1 while at least one capture is stored, and 0 once the store is empty.
- R2: A control write (address 1) with bit 0 set, made while the handshake is idle and a capture is stored, copies the oldest capture into the snapshot registers. If the store is empty, the write is ignored.
- R3: A control write with bit 1 set, made after an accepted start, removes that capture from the store. Until a control write of 0 follows, a further start write is ignored.
- R4: Snapshot words are mapped as follows: address 2 holds nanoseconds [15:0], address 3 nanoseconds [31:16], address 4 seconds [15:0] and address 5 seconds [31:16].
- R5: Address 6 returns the 16-bit sequence number of the snapshot.
- R6: Address 7 returns the message type in bits [15:12] and the transmit flag in bit 11. All other bits read 0.
- R7: A transmit capture is stored only while both `tx_cap_en_i` and `tx_slice_en_i` are 1. A receive capture is always stored.
- R8: The store holds DEPTH entries (8 by default). A capture that arrives when all entries are occupied is dropped and sets status bit 2, which stays set until reset.
- R9: The snapshot words do not change between an accepted start and the following end, even when new captures are stored in that time.
- R10: An end write made while the handshake is idle is ignored and removes nothing.
- R11: Captures are read out in the order they were stored.
- R12: `reg_rdata_o` is registered. It shows the register addressed in the previous cycle. It is 0 after reset, and address 1 always reads 0.
- R13: A control write with any of bits [15:2] set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid_i | input | 1 | One-cycle capture strobe |
| cap_sec_i | input | 32 | Seconds part of the capture time |
| cap_nsec_i | input | 32 | Nanoseconds part of the capture time |
| cap_seq_i | input | 16 | Sequence number of the frame |
| cap_mtype_i | input | 4 | Message type of the frame |
| cap_is_tx_i | input | 1 | 1 for a transmit capture, 0 for a receive capture |
| tx_cap_en_i | input | 1 | Transmit capture enable |
| tx_slice_en_i | input | 1 | Transmit slice enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data |
| stamp_pending_o | output | 1 | At least one capture is waiting |

## Verification
The hardest condition to reach is a new capture arriving while a snapshot is held. The bench reaches it by opening a read and then driving further captures before it reads the words, and it checks that the words still describe the first capture. It also reaches the store-full condition by driving DEPTH+1 receive captures with no reads in between. A start write issued between the end write and the write of 0 exercises the return-to-idle rule: the bench checks that the snapshot keeps the released capture.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;

  localparam int REG_W = 16;
  localparam int RA_W  = 3;

  typedef struct packed {
    logic [31:0] sec;
    logic [31:0] nsec;
    logic [15:0] seq;
    logic [3:0]  mtype;
    logic        is_tx;
  } stamp_t;

  localparam int STAMP_W = $bits(stamp_t);

  localparam logic [RA_W-1:0] RA_STATUS = 3'd0;
  localparam logic [RA_W-1:0] RA_CTRL   = 3'd1;
  localparam logic [RA_W-1:0] RA_NS_LO  = 3'd2;
  localparam logic [RA_W-1:0] RA_NS_HI  = 3'd3;
  localparam logic [RA_W-1:0] RA_S_LO   = 3'd4;
  localparam logic [RA_W-1:0] RA_S_HI   = 3'd5;
  localparam logic [RA_W-1:0] RA_SEQ    = 3'd6;
  localparam logic [RA_W-1:0] RA_INFO   = 3'd7;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_HELD = 2'd1,
    RD_DONE = 2'd2
  } rd_state_e;

endpackage

// File: rtl/evt_stamp_fifo.sv
module evt_stamp_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 85
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             ovf_q;
  logic             full, push_ok, pop_ok;

  assign full    = (count == FULL);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && (count != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din_i;
  end

  assign head_o = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assign empty_o = (count == '0);
  assign ovf_o   = ovf_q;

  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  p_drop_sets_ovf_r8: assert property (@(posedge clk) disable iff (rst)
    (push_i && count == FULL) |=> ovf_q);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(ovf_q) |-> ovf_q);
  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> (count != '0));
  p_pend_rise_r1: assert property (@(posedge clk) disable iff (rst)
    ((count != '0) && $past(count == '0)) |-> $past(push_i));

endmodule

// File: rtl/evt_stamp_readout.sv
module evt_stamp_readout
  import evt_stamp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [RA_W-1:0]  addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  stamp_t           head_i,
  input  logic             empty_i,
  input  logic             ovf_i,
  output logic             pop_o,
  output logic [REG_W-1:0] rdata_o
);
  rd_state_e state;
  stamp_t    snap;
  logic      ctrl_wr;

  assign ctrl_wr = wr_i && (addr_i == RA_CTRL) && (wdata_i[REG_W-1:2] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RD_IDLE;
      snap  <= '0;
    end else begin
      unique case (state)
        RD_IDLE: if (ctrl_wr && wdata_i[0] && !empty_i) begin
          snap  <= head_i;
          state <= RD_HELD;
        end
        RD_HELD: if (ctrl_wr && wdata_i[1]) state <= RD_DONE;
        RD_DONE: if (ctrl_wr && wdata_i[1:0] == 2'b00) state <= RD_IDLE;
        default: state <= RD_IDLE;
      endcase
    end
  end

  assign pop_o = (state == RD_HELD) && ctrl_wr && wdata_i[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      unique case (addr_i)
        RA_STATUS: rdata_o <= {{(REG_W-3){1'b0}}, ovf_i, !empty_i, 1'b0};
        RA_NS_LO:  rdata_o <= snap.nsec[15:0];
        RA_NS_HI:  rdata_o <= snap.nsec[31:16];
        RA_S_LO:   rdata_o <= snap.sec[15:0];
        RA_S_HI:   rdata_o <= snap.sec[31:16];
        RA_SEQ:    rdata_o <= snap.seq;
        RA_INFO:   rdata_o <= {snap.mtype, snap.is_tx, 11'b0};
        default:   rdata_o <= '0;
      endcase
    end
  end

  p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state == RD_HELD && $past(state) == RD_HELD) |-> $stable(snap));
  p_held_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
    (state == RD_HELD) |-> !empty_i);

endmodule

// File: rtl/evt_stamp_regs.sv
module evt_stamp_regs
  import evt_stamp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_valid_i,
  input  logic [31:0]      cap_sec_i,
  input  logic [31:0]      cap_nsec_i,
  input  logic [15:0]      cap_seq_i,
  input  logic [3:0]       cap_mtype_i,
  input  logic             cap_is_tx_i,
  input  logic             tx_cap_en_i,
  input  logic             tx_slice_en_i,
  input  logic             reg_wr_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             stamp_pending_o
);
  stamp_t cap_in, head;
  logic   accept, empty, ovf, pop;

  assign accept = cap_valid_i && (!cap_is_tx_i || (tx_cap_en_i && tx_slice_en_i));

  always_comb begin
    cap_in.sec   = cap_sec_i;
    cap_in.nsec  = cap_nsec_i;
    cap_in.seq   = cap_seq_i;
    cap_in.mtype = cap_mtype_i;
    cap_in.is_tx = cap_is_tx_i;
  end

  evt_stamp_fifo #(.DEPTH(DEPTH), .WIDTH(STAMP_W)) fifo_i (
    .clk     (clk),
    .rst     (rst),
    .push_i  (accept),
    .din_i   (cap_in),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty),
    .ovf_o   (ovf)
  );

  evt_stamp_readout rd_i (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .head_i  (head),
    .empty_i (empty),
    .ovf_i   (ovf),
    .pop_o   (pop),
    .rdata_o (reg_rdata_o)
  );

  assign stamp_pending_o = !empty;

  p_tx_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (cap_valid_i && cap_is_tx_i && !(tx_cap_en_i && tx_slice_en_i) && empty && !pop)
      |=> !stamp_pending_o);

endmodule

// File: tb/evt_stamp_regs_tb_top.sv
module evt_stamp_regs_tb_top;
  import evt_stamp_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_valid_i = 1'b0;
  logic [31:0] cap_sec_i = '0, cap_nsec_i = '0;
  logic [15:0] cap_seq_i = '0;
  logic [3:0]  cap_mtype_i = '0;
  logic        cap_is_tx_i = 1'b0;
  logic        tx_cap_en_i = 1'b0, tx_slice_en_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        stamp_pending_o;

  int checks = 0;
  int errors = 0;
  stamp_t exp_q[$];

  always #2 clk = ~clk;

  evt_stamp_regs #(.DEPTH(8)) dut_i (.*);

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr_i = a;
    @(negedge clk);
    v = reg_rdata_o;
  endtask

  function automatic stamp_t mk(int i, bit tx);
    stamp_t s;
    s.sec   = 32'h6100_0000 + 32'(i * 32'h0001_0003);
    s.nsec  = 32'h0A00_0000 + 32'(i * 32'h0002_0011);
    s.seq   = 16'h3000 + 16'(i);
    s.mtype = 4'(i);
    s.is_tx = tx;
    return s;
  endfunction

  // Driver: applies a capture and records it as expected when it should be stored.
  task automatic capture(stamp_t s, bit store);
    @(negedge clk);
    cap_valid_i = 1'b1; cap_sec_i = s.sec; cap_nsec_i = s.nsec;
    cap_seq_i = s.seq; cap_mtype_i = s.mtype; cap_is_tx_i = s.is_tx;
    @(negedge clk);
    cap_valid_i = 1'b0;
    if (store) exp_q.push_back(s);
  endtask

  task automatic check_words(string tag, stamp_t e);
    logic [15:0] v;
    rd_reg(RA_NS_LO, v); check({tag, " R4 ns lo"}, v, e.nsec[15:0]);
    rd_reg(RA_NS_HI, v); check({tag, " R4 ns hi"}, v, e.nsec[31:16]);
    rd_reg(RA_S_LO, v);  check({tag, " R4 s lo"},  v, e.sec[15:0]);
    rd_reg(RA_S_HI, v);  check({tag, " R4 s hi"},  v, e.sec[31:16]);
    rd_reg(RA_SEQ, v);   check({tag, " R5 seq"},   v, e.seq);
    rd_reg(RA_INFO, v);  check({tag, " R6 info"},  v, {e.mtype, e.is_tx, 11'b0});
  endtask

  // Monitor: pops the oldest expected capture and compares the readout.
  task automatic drain_one(string tag);
    stamp_t e;
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL %s R11: actual no expected entry expected one", tag);
      return;
    end
    e = exp_q.pop_front();
    wr_reg(RA_CTRL, 16'h0001);
    check_words(tag, e);
    wr_reg(RA_CTRL, 16'h0002);
    wr_reg(RA_CTRL, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    stamp_t a;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // Reset state
    check("R12 reset rdata", reg_rdata_o, 16'h0000);
    check("R1 reset pending", {15'b0, stamp_pending_o}, 16'h0000);
    rd_reg(RA_STATUS, v); check("R1 reset status", v, 16'h0000);

    // R10: end without start is ignored
    capture(mk(1, 1'b0), 1'b1);
    check("R1 pending after capture", {15'b0, stamp_pending_o}, 16'h0001);
    wr_reg(RA_CTRL, 16'h0002);
    rd_reg(RA_STATUS, v); check("R10 end in idle ignored", v, 16'h0002);
    rd_reg(RA_CTRL, v); check("R12 ctrl reads zero", v, 16'h0000);
    // R13: reserved bits block a control write
    wr_reg(RA_CTRL, 16'h0005);
    wr_reg(RA_CTRL, 16'h0002);
    rd_reg(RA_STATUS, v); check("R13 reserved bits ignored", v, 16'h0002);
    drain_one("first");
    check("R1 pending clears", {15'b0, stamp_pending_o}, 16'h0000);
    rd_reg(RA_STATUS, v); check("R1 status clears", v, 16'h0000);

    // R2: start with empty store ignored, snapshot keeps entry 1
    wr_reg(RA_CTRL, 16'h0001);
    rd_reg(RA_SEQ, v); check("R2 empty start keeps snapshot", v, mk(1, 1'b0).seq);
    capture(mk(2, 1'b0), 1'b1);
    drain_one("after empty start");

    // R7: transmit gating
    tx_cap_en_i = 1'b0; tx_slice_en_i = 1'b1;
    capture(mk(3, 1'b1), 1'b0);
    check("R7 tx gated cap_en", {15'b0, stamp_pending_o}, 16'h0000);
    tx_cap_en_i = 1'b1; tx_slice_en_i = 1'b0;
    capture(mk(4, 1'b1), 1'b0);
    check("R7 tx gated slice_en", {15'b0, stamp_pending_o}, 16'h0000);
    capture(mk(5, 1'b0), 1'b1);
    check("R7 rx stored while tx gated", {15'b0, stamp_pending_o}, 16'h0001);
    tx_slice_en_i = 1'b1;
    capture(mk(6, 1'b1), 1'b1);
    drain_one("R7 rx");
    drain_one("R7 tx");

    // R11: order
    for (int i = 10; i < 13; i++) capture(mk(i, i[0]), 1'b1);
    for (int i = 0; i < 3; i++) drain_one("R11 order");

    // R9: snapshot stable while new captures arrive
    capture(mk(20, 1'b0), 1'b1);
    wr_reg(RA_CTRL, 16'h0001);
    capture(mk(21, 1'b1), 1'b1);
    capture(mk(22, 1'b0), 1'b1);
    a = exp_q.pop_front();
    check_words("R9 held", a);
    wr_reg(RA_CTRL, 16'h0002);
    wr_reg(RA_CTRL, 16'h0000);
    drain_one("R9 next");

    // R3: start before write of 0 ignored
    a = exp_q.pop_front();
    wr_reg(RA_CTRL, 16'h0001);
    wr_reg(RA_CTRL, 16'h0002);
    wr_reg(RA_CTRL, 16'h0001);
    rd_reg(RA_SEQ, v); check("R3 start in done ignored", v, a.seq);
    rd_reg(RA_STATUS, v); check("R3 pop only one", v, 16'h0000);
    wr_reg(RA_CTRL, 16'h0000);
    capture(mk(30, 1'b0), 1'b1);
    drain_one("R3 after idle");

    // R8: overflow
    for (int i = 40; i < 48; i++) capture(mk(i, 1'b0), 1'b1);
    rd_reg(RA_STATUS, v); check("R8 full no ovf", v, 16'h0002);
    capture(mk(48, 1'b0), 1'b0);
    rd_reg(RA_STATUS, v); check("R8 ovf set", v, 16'h0006);
    for (int i = 0; i < 8; i++) drain_one("R8 drain");
    rd_reg(RA_STATUS, v); check("R8 ovf sticky", v, 16'h0004);
    check("R1 empty after drain", {15'b0, stamp_pending_o}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule